// File: doc/BRIEF.md
# Reset Sequencing Controller

This block turns two reset sources into one ordered bring-up of a processor subsystem. The first source is an asynchronous active-low reset pin. The second is an internal power-on request from analog supply monitoring. The pin is synchronized and then passed through a minimum-width filter, so that short glitches never reset the chip. A programmable 2-bit behaviour field chooses what a recognised pin reset does. It can start a power-on style sequence, which waits, releases reset, runs a full device initialization and then fetches the boot vectors. It can instead start a shorter system reset sequence, which releases reset and goes straight to the vector fetch.

The block holds the core and peripheral reset outputs asserted until the chosen sequence releases them. It talks to an external initialization engine and to a vector fetch stage through request/done handshakes, and it raises a run indication when execution may begin. A small cause register records which kind of event started the last sequence, and software clears it by writing ones. Any new recognised reset, and any new power-on request, aborts the current sequence and starts again from the top of the selected path.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While `rst` is high and right after it, `core_rst` and `periph_rst` are 1; `run`, `init_req` and `fetch_req` are 0; `cause_q` is 3'b001 and `beh_q` is 2'b00. With `por_req` low, a full sequence then follows.
- R2: A pin reset is recognised only if `ext_rst_n` stays low for at least MIN_CYCLES consecutive clock cycles. A pulse of MIN_CYCLES-1 cycles changes no output.
- R3: When a pin reset is recognised, a behaviour field of 2'b10 selects the system sequence. The values 2'b00, 2'b01 and 2'b11 select the full sequence.
- R4: In the full sequence, the reset outputs stay asserted while the pin is still low and while `por_req` is high. After that, reset is released together with `init_req`. After `init_done` comes `fetch_req`, and after `fetch_done` comes `run`.
- R5: The system sequence never raises `init_req`. Once the pin is released, it releases reset, raises `fetch_req`, and then raises `run` after `fetch_done`.
- R6: A rising `por_req` forces the full sequence whatever the behaviour field holds. Reset is asserted on the next cycle and stays asserted while `por_req` is high.
- R7: A recognised pin reset or a rising `por_req` during any phase aborts that phase: a pending `init_req` drops and the new path starts from its beginning.
- R8: Starting a full sequence clears the behaviour field to 2'b00. A system sequence leaves it unchanged.
- R9: `cause_q` bit 0 marks a power-on request, bit 1 a pin reset run as a full sequence, and bit 2 a pin reset run as a system sequence. A sequence start overwrites the register with exactly that one bit. A 1 in `cause_clr` clears the matching bit, and bits with 0 in `cause_clr` are kept.
- R10: `init_req`, `fetch_req` and `run` are never high together. Each request stays high until its done input is seen, unless an abort happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high register reset |
| ext_rst_n | input | 1 | Asynchronous active-low external reset pin |
| por_req | input | 1 | Internal power-on reset request (level) |
| beh_wr | input | 1 | Write strobe for the behaviour field |
| beh_wdata | input | 2 | New behaviour field value |
| beh_q | output | 2 | Current behaviour field |
| cause_clr | input | 3 | Write-one-to-clear mask for the cause register |
| cause_q | output | 3 | Cause of the last reset sequence |
| init_req | output | 1 | Request to the initialization engine |
| init_done | input | 1 | Initialization finished |
| fetch_req | output | 1 | Request to the vector fetch stage |
| fetch_done | input | 1 | Vector fetch finished |
| core_rst | output | 1 | Core reset, active high |
| periph_rst | output | 1 | Peripheral reset, active high |
| run | output | 1 | Execution may begin |

## Verification
The bench drives pin pulses of exactly MIN_CYCLES-1 and MIN_CYCLES cycles. A filter that is off by one cycle either resets the chip on a glitch or misses a legal pulse. It selects the system path with field 2'b10 and checks that `init_req` never appears and that the field survives. A design that decoded the field wrongly, or cleared it on every reset, would run initialization or lose the setting. It also aborts a sequence that is stalled in initialization and raises `por_req` while 2'b10 is programmed. A design that ignored aborts would hang in its old phase, and one that let the field override a power-on request would skip initialization. Finally it holds the pin low for a long time, to catch a design that releases reset before the pin is released.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

    typedef enum logic [2:0] {
        ST_WAIT_PIN  = 3'd0,
        ST_WAIT_POR  = 3'd1,
        ST_INIT      = 3'd2,
        ST_FETCH     = 3'd3,
        ST_RUN       = 3'd4
    } seq_state_t;

    // bit 0 = power-on request, bit 1 = pin as full, bit 2 = pin as system
    typedef struct packed {
        logic pin_sys;
        logic pin_full;
        logic por;
    } cause_t;

    localparam int CAUSE_W = $bits(cause_t);
    localparam int BEH_W   = 2;
    localparam logic [BEH_W-1:0] BEH_SYSTEM = 2'b10;
    localparam logic [BEH_W-1:0] BEH_RESET  = 2'b00;

    function automatic logic beh_selects_full(input logic [BEH_W-1:0] beh);
        return beh != BEH_SYSTEM;
    endfunction

endpackage

// File: rtl/rst_pin_filter.sv
module rst_pin_filter #(
    parameter int MIN_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic pin_hit,
    output logic pin_released
);
    localparam int CW = $clog2(MIN_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(MIN_CYCLES - 1);
    localparam logic [CW-1:0] FULL = CW'(MIN_CYCLES);

    logic          meta_q;
    logic          sync_q;
    logic [CW-1:0] low_cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
        end else begin
            meta_q <= pin_n;
            sync_q <= meta_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || sync_q) begin
            low_cnt_q <= '0;
        end else if (low_cnt_q != FULL) begin
            low_cnt_q <= low_cnt_q + 1'b1;
        end
    end

    assign pin_hit      = !sync_q && (low_cnt_q == LAST);
    assign pin_released = sync_q;

endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
    import rst_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             por_req,
    input  logic             pin_hit,
    input  logic             pin_released,
    input  logic [BEH_W-1:0] beh,
    input  logic             init_done,
    input  logic             fetch_done,
    output cause_t           start_cause,
    output logic             start_full,
    output logic             hold_rst,
    output logic             init_req,
    output logic             fetch_req,
    output logic             run
);
    seq_state_t state_q;
    logic       full_q;
    logic       por_q;
    logic       por_rise;
    logic       pin_full;

    assign por_rise = por_req && !por_q;
    assign pin_full = por_req || beh_selects_full(beh);

    always_comb begin
        start_cause = '0;
        start_full  = 1'b0;
        if (por_rise) begin
            start_cause.por = 1'b1;
            start_full      = 1'b1;
        end else if (pin_hit) begin
            start_cause.pin_full = pin_full;
            start_cause.pin_sys  = !pin_full;
            start_full           = pin_full;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_WAIT_PIN;
            full_q  <= 1'b1;
            por_q   <= 1'b0;
        end else begin
            por_q <= por_req;
            if (por_rise || pin_hit) begin
                state_q <= ST_WAIT_PIN;
                full_q  <= start_full;
            end else begin
                unique case (state_q)
                    ST_WAIT_PIN: if (pin_released)
                                     state_q <= full_q ? ST_WAIT_POR : ST_FETCH;
                    ST_WAIT_POR: if (!por_req)   state_q <= ST_INIT;
                    ST_INIT:     if (init_done)  state_q <= ST_FETCH;
                    ST_FETCH:    if (fetch_done) state_q <= ST_RUN;
                    ST_RUN:      state_q <= ST_RUN;
                    default:     state_q <= ST_WAIT_PIN;
                endcase
            end
        end
    end

    assign hold_rst  = (state_q == ST_WAIT_PIN) || (state_q == ST_WAIT_POR);
    assign init_req  = (state_q == ST_INIT);
    assign fetch_req = (state_q == ST_FETCH);
    assign run       = (state_q == ST_RUN);

endmodule

// File: rtl/rst_seq_status.sv
module rst_seq_status
    import rst_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  cause_t             start_cause,
    input  logic               start_full,
    input  logic [CAUSE_W-1:0] cause_clr,
    input  logic               beh_wr,
    input  logic [BEH_W-1:0]   beh_wdata,
    output logic [BEH_W-1:0]   beh_q,
    output logic [CAUSE_W-1:0] cause_q
);
    cause_t cause_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_r     <= '0;
            cause_r.por <= 1'b1;
        end else if (start_cause != '0) begin
            cause_r <= start_cause;
        end else begin
            cause_r <= cause_r & ~cause_t'(cause_clr);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || start_full) begin
            beh_q <= BEH_RESET;
        end else if (beh_wr) begin
            beh_q <= beh_wdata;
        end
    end

    assign cause_q = cause_r;

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
    import rst_seq_pkg::*;
#(
    parameter int MIN_CYCLES = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ext_rst_n,
    input  logic               por_req,
    input  logic               beh_wr,
    input  logic [BEH_W-1:0]   beh_wdata,
    output logic [BEH_W-1:0]   beh_q,
    input  logic [CAUSE_W-1:0] cause_clr,
    output logic [CAUSE_W-1:0] cause_q,
    output logic               init_req,
    input  logic               init_done,
    output logic               fetch_req,
    input  logic               fetch_done,
    output logic               core_rst,
    output logic               periph_rst,
    output logic               run
);
    logic   pin_hit;
    logic   pin_released;
    logic   hold_rst;
    logic   start_full;
    cause_t start_cause;

    rst_pin_filter #(.MIN_CYCLES(MIN_CYCLES)) filt_i (
        .clk          (clk),
        .rst          (rst),
        .pin_n        (ext_rst_n),
        .pin_hit      (pin_hit),
        .pin_released (pin_released)
    );

    rst_seq_fsm fsm_i (
        .clk          (clk),
        .rst          (rst),
        .por_req      (por_req),
        .pin_hit      (pin_hit),
        .pin_released (pin_released),
        .beh          (beh_q),
        .init_done    (init_done),
        .fetch_done   (fetch_done),
        .start_cause  (start_cause),
        .start_full   (start_full),
        .hold_rst     (hold_rst),
        .init_req     (init_req),
        .fetch_req    (fetch_req),
        .run          (run)
    );

    rst_seq_status stat_i (
        .clk          (clk),
        .rst          (rst),
        .start_cause  (start_cause),
        .start_full   (start_full),
        .cause_clr    (cause_clr),
        .beh_wr       (beh_wr),
        .beh_wdata    (beh_wdata),
        .beh_q        (beh_q),
        .cause_q      (cause_q)
    );

    assign core_rst   = hold_rst;
    assign periph_rst = hold_rst;

endmodule

// File: rtl/rst_seq_ctrl_chk.sv
module rst_seq_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       por_req,
    input logic [2:0] cause_q,
    input logic       init_req,
    input logic       init_done,
    input logic       fetch_req,
    input logic       core_rst,
    input logic       run
);
    // R10
    excl_phase_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({init_req, fetch_req, run}));

    // R4
    rst_blocks_phase_chk: assert property (@(posedge clk) disable iff (rst)
        core_rst |-> !(init_req || fetch_req || run));

    // R10
    init_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (init_req && !init_done) |=> (init_req || core_rst));

    // R6
    por_holds_rst_chk: assert property (@(posedge clk) disable iff (rst)
        por_req |=> core_rst);

    // R6
    por_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(por_req) |=> (cause_q == 3'b001));

    // R9
    cause_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cause_q));
endmodule

bind rst_seq_ctrl rst_seq_ctrl_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .por_req   (por_req),
    .cause_q   (cause_q),
    .init_req  (init_req),
    .init_done (init_done),
    .fetch_req (fetch_req),
    .core_rst  (core_rst),
    .run       (run)
);

// File: tb/rst_seq_ctrl_tb_top.sv
module rst_seq_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MINC       = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ext_rst_n = 1'b1;
    logic       por_req = 1'b0;
    logic       beh_wr = 1'b0;
    logic [1:0] beh_wdata = 2'b00;
    logic [1:0] beh_q;
    logic [2:0] cause_clr = 3'b000;
    logic [2:0] cause_q;
    logic       init_req, fetch_req, core_rst, periph_rst, run;
    logic       init_done = 1'b0;
    logic       fetch_done = 1'b0;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rst_seq_ctrl #(.MIN_CYCLES(MINC)) dut_i (
        .clk(clk), .rst(rst), .ext_rst_n(ext_rst_n), .por_req(por_req),
        .beh_wr(beh_wr), .beh_wdata(beh_wdata), .beh_q(beh_q),
        .cause_clr(cause_clr), .cause_q(cause_q),
        .init_req(init_req), .init_done(init_done),
        .fetch_req(fetch_req), .fetch_done(fetch_done),
        .core_rst(core_rst), .periph_rst(periph_rst), .run(run)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic write_beh(input logic [1:0] v);
        @(negedge clk); beh_wr = 1'b1; beh_wdata = v;
        @(negedge clk); beh_wr = 1'b0;
    endtask

    task automatic pulse_pin(input int n);
        @(negedge clk); ext_rst_n = 1'b0;
        repeat (n) @(negedge clk);
        ext_rst_n = 1'b1;
    endtask

    // Answers handshakes until run; checks the order of phases.
    task automatic serve(input string req, input logic exp_init);
        logic saw_init = 1'b0, saw_fetch = 1'b0, bad = 1'b0;
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            init_done = 1'b0; fetch_done = 1'b0;
            if (run) break;
            if (init_req) begin
                saw_init = 1'b1;
                if (saw_fetch || core_rst || periph_rst) bad = 1'b1;
                init_done = 1'b1;
            end else if (fetch_req) begin
                saw_fetch = 1'b1;
                if (core_rst || periph_rst) bad = 1'b1;
                fetch_done = 1'b1;
            end
        end
        init_done = 1'b0; fetch_done = 1'b0;
        check({req, " run reached"}, run, 1'b1);
        check({req, " init phase seen"}, saw_init, exp_init);
        check({req, " fetch phase seen"}, saw_fetch, 1'b1);
        check({req, " phase order"}, bad, 1'b0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        // R1
        check("R1 core_rst", core_rst, 1'b1);
        check("R1 periph_rst", periph_rst, 1'b1);
        check("R1 run", run, 1'b0);
        check("R1 requests", {init_req, fetch_req}, 2'b00);
        check("R1 cause", cause_q, 3'b001);
        check("R1 beh", beh_q, 2'b00);
        rst = 1'b0;
        serve("R1 R4 power-up", 1'b1);
    endtask

    task automatic t_short_pulse();
        logic moved = 1'b0;
        pulse_pin(MINC - 1);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (core_rst || !run) moved = 1'b1;
        end
        check("R2 short pulse ignored", moved, 1'b0);
        check("R2 cause unchanged", cause_q, 3'b001);
    endtask

    task automatic t_pin_default();
        pulse_pin(MINC);
        repeat (4) @(negedge clk);
        check("R2 R3 R9 cause pin full (00)", cause_q, 3'b010);
        serve("R3 R4 pin default", 1'b1);
    endtask

    task automatic t_pin_sys();
        write_beh(2'b10);
        pulse_pin(MINC);
        repeat (4) @(negedge clk);
        check("R3 R9 cause pin system", cause_q, 3'b100);
        serve("R5 system path", 1'b0);
        check("R8 beh kept after system reset", beh_q, 2'b10);
    endtask

    task automatic t_pin_full11();
        write_beh(2'b11);
        pulse_pin(MINC);
        repeat (4) @(negedge clk);
        check("R3 cause pin full (11)", cause_q, 3'b010);
        check("R8 beh cleared by full path", beh_q, 2'b00);
        serve("R3 pin 11", 1'b1);
    endtask

    task automatic t_pin_01();
        write_beh(2'b01);
        pulse_pin(MINC);
        repeat (4) @(negedge clk);
        check("R3 cause pin full (01)", cause_q, 3'b010);
        serve("R3 pin 01", 1'b1);
    endtask

    task automatic t_long_hold();
        @(negedge clk); ext_rst_n = 1'b0;
        repeat (40) @(negedge clk);
        check("R4 rst held while pin low", {core_rst, periph_rst}, 2'b11);
        check("R4 no init while pin low", init_req, 1'b0);
        ext_rst_n = 1'b1;
        serve("R4 long hold", 1'b1);
    endtask

    task automatic t_por();
        write_beh(2'b10);
        @(negedge clk); por_req = 1'b1;
        repeat (30) @(negedge clk);
        check("R6 rst held during por", core_rst, 1'b1);
        check("R6 cause por", cause_q, 3'b001);
        check("R8 beh cleared by por", beh_q, 2'b00);
        por_req = 1'b0;
        serve("R6 por full path", 1'b1);
    endtask

    task automatic t_abort();
        logic got = 1'b0;
        pulse_pin(MINC);
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (init_req) begin got = 1'b1; break; end
        end
        check("R7 reached init", got, 1'b1);
        write_beh(2'b10);
        check("R10 init held without done", init_req, 1'b1);
        pulse_pin(MINC);
        repeat (4) @(negedge clk);
        check("R7 init dropped on abort", init_req, 1'b0);
        check("R7 cause after abort", cause_q, 3'b100);
        serve("R7 restart system path", 1'b0);
    endtask

    task automatic t_w1c();
        @(negedge clk); cause_clr = 3'b011;
        @(negedge clk); cause_clr = 3'b000;
        check("R9 w1c other bits keep", cause_q, 3'b100);
        @(negedge clk); cause_clr = 3'b100;
        @(negedge clk); cause_clr = 3'b000;
        check("R9 w1c clears bit", cause_q, 3'b000);
    endtask

    initial begin
        t_reset();
        t_short_pulse();
        t_pin_default();
        t_pin_sys();
        t_pin_full11();
        t_pin_01();
        t_long_hold();
        t_por();
        t_abort();
        t_w1c();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule